// File: doc/BRIEF.md
# Trim Control Register Target on I2C

This block is an I2C target that lets a host microcontroller program the control registers of a multi-channel closed-loop voltage trim engine. The same bus port also reaches a slower downstream device. Register addresses 0x00 through 0x1A are relayed to that device as single-byte read or write requests over a request/done handshake. All higher addresses are served from a local register file. That file holds, for each channel, a 12-bit trim target with an attenuation select, an 8-bit DAC start code, an enable bit and a polarity bit.

The target never stretches SCL. When it cannot take a transfer because a relayed request is still outstanding, or when a relayed read has not yet returned its data, it leaves its own address byte unacknowledged. The host then retries the frame. A register write is a single frame: device address with the write bit, then the register pointer, then one data byte. A register read takes two frames: a write frame that carries only the pointer, then a read frame that returns one byte.

SCL and SDA pass through a two-flop synchronizer and a glitch filter clocked by the system clock. START and STOP are recognised as SDA edges while SCL is high. SDA is handled as an open-drain line: the block either pulls it low or leaves it released.

Top module: `trim_reg_target`

## Requirements
- R1: The 7-bit device address is a parameter with default 0x20. A frame whose address byte carries any other address gets no ACK on any byte, and it changes no register until the next START.
- R2: A write frame (address+W, pointer, data) is acknowledged on all three bytes. The addressed local register takes the data byte when that byte ends, and local registers change at no other time.
- R3: A read is a pointer-only write frame followed by a read frame. After ACKing its address, the target returns one byte MSB first and then releases SDA.
- R4: While a relayed request is outstanding (fwd_req_o high), the address byte of a write frame is not acknowledged, and the rest of that frame is ignored.
- R5: A read frame aimed at a pointer in 0x00–0x1A gets no ACK until downstream data has arrived. The first refused poll launches a downstream read (fwd_we_o=0). The next poll after fwd_done_i is acknowledged and returns fwd_rdata_i. Each returned byte is used for only one read.
- R6: A data byte written to a pointer in 0x00–0x1A raises fwd_req_o with fwd_we_o=1, fwd_addr_o equal to the pointer and fwd_wdata_o equal to the data. These outputs stay unchanged until the cycle in which fwd_done_i is high.
- R7: Local map: channel n target high byte at 0x20+2(n-1) and low byte one above it; DAC code at 0x30+(n-1); enable byte at 0x38; polarity byte at 0x3A. Bit n-1 of the enable and polarity bytes belongs to channel n. After reset, targets are 0, DAC codes are 0x80, and enable and polarity are 0.
- R8: In a target high byte, bit 7 is the attenuation select, bits 3–0 are target bits 11–8, and bits 6–4 are dropped on write and read back as 0.
- R9: Address 0x39 and every unmapped address above 0x1A read as 0x00, and writes to them are acknowledged but have no effect.
- R10: The target only pulls SDA low or releases it, and it only starts pulling while SCL is low.
- R11: A fourth byte in a write frame is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| fwd_req_o | output | 1 | Relayed request outstanding |
| fwd_we_o | output | 1 | 1 for a relayed write, 0 for a relayed read |
| fwd_addr_o | output | 8 | Register address of the relayed request |
| fwd_wdata_o | output | 8 | Data of a relayed write |
| fwd_done_i | input | 1 | Downstream completion, one cycle |
| fwd_rdata_i | input | 8 | Downstream read data, valid with fwd_done_i |
| chan_en_o | output | 8 | Per-channel enable |
| chan_pol_o | output | 8 | Per-channel loop polarity |
| dac_code_o | output | 64 | DAC start codes, channel n at bits 8n-1:8(n-1) |
| tgt_code_o | output | 96 | 12-bit targets, channel n at bits 12n-1:12(n-1) |
| tgt_atten_o | output | 8 | Per-channel attenuation select |

## Verification
Several properties are checked every cycle. The relayed request must stay stable until it completes, and it must never name an address above 0x1A. Relayed read data may only become valid after a downstream completion. Local enable bits change only on a data byte. The reserved address reads as zero. SDA is never newly pulled while SCL is high, and it is released after any START. Other behaviour can only be shown by the bench scenarios: the frame-level ACK/NACK pattern, NACK on busy and the retry that follows, the refuse-launch-then-deliver sequence of a relayed read, the field packing of the target bytes, and how foreign addresses and surplus bytes are ignored.

// File: rtl/trim_i2c_pkg.sv
package trim_i2c_pkg;

    localparam logic [7:0] FWD_LAST = 8'h1A;
    localparam logic [7:0] TGT_BASE = 8'h20;
    localparam logic [7:0] DAC_BASE = 8'h30;
    localparam logic [7:0] EN_ADDR  = 8'h38;
    localparam logic [7:0] RSV_ADDR = 8'h39;
    localparam logic [7:0] POL_ADDR = 8'h3A;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_RX,
        BS_ACK,
        BS_TX,
        BS_MACK
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_REG,
        PH_DATA,
        PH_DONE
    } frame_phase_e;

    typedef struct packed {
        logic        atten;
        logic [11:0] code;
    } target_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic scl;
    } bus_ev_t;

    function automatic logic is_fwd(input logic [7:0] a);
        return a <= FWD_LAST;
    endfunction

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    logic [1:0]    meta;
    logic          filt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 2'b11;
            filt <= 1'b1;
            cnt  <= '0;
        end else begin
            meta <= {meta[0], pin_i};
            if (meta[1] == filt) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_LEN - 1)) begin
                filt <= meta[1];
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign level_o = filt;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import trim_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h20
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic       wr_ok,
    input  logic       rd_ok,
    input  logic [7:0] rd_byte,
    output logic       sda_pull,
    output logic       ptr_stb,
    output logic       wdata_stb,
    output logic       rd_addr_stb,
    output logic [7:0] rx_byte
);
    bus_state_e   state;
    frame_phase_e phase;
    logic [3:0]   cnt;
    logic [7:0]   sh;
    logic         tx_next;

    logic byte_done, dev_match, ack_now;

    always_comb begin
        byte_done = (state == BS_RX) && ev.scl_fall && (cnt == 4'd8);
        dev_match = (sh[7:1] == DEV_ADDR);
        case (phase)
            PH_DEV:  ack_now = dev_match && (sh[0] ? rd_ok : wr_ok);
            PH_REG:  ack_now = 1'b1;
            PH_DATA: ack_now = 1'b1;
            default: ack_now = 1'b0;
        endcase
    end

    assign ptr_stb     = byte_done && (phase == PH_REG);
    assign wdata_stb   = byte_done && (phase == PH_DATA);
    assign rd_addr_stb = byte_done && (phase == PH_DEV) && dev_match && sh[0];
    assign rx_byte     = sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= BS_IDLE;
            phase    <= PH_DEV;
            cnt      <= '0;
            sh       <= '0;
            tx_next  <= 1'b0;
            sda_pull <= 1'b0;
        end else if (ev.start) begin
            state    <= BS_RX;
            phase    <= PH_DEV;
            cnt      <= '0;
            sda_pull <= 1'b0;
        end else if (ev.stop) begin
            state    <= BS_IDLE;
            sda_pull <= 1'b0;
        end else begin
            case (state)
                BS_RX: begin
                    if (ev.scl_rise && cnt < 4'd8) begin
                        sh  <= {sh[6:0], ev.sda};
                        cnt <= cnt + 4'd1;
                    end
                    if (byte_done) begin
                        if (ack_now) begin
                            sda_pull <= 1'b1;
                            state    <= BS_ACK;
                            tx_next  <= (phase == PH_DEV) && sh[0];
                            case (phase)
                                PH_DEV:  phase <= PH_REG;
                                PH_REG:  phase <= PH_DATA;
                                default: phase <= PH_DONE;
                            endcase
                        end else begin
                            state <= BS_IDLE;
                        end
                    end
                end
                BS_ACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (tx_next) begin
                            sh       <= {rd_byte[6:0], 1'b0};
                            sda_pull <= ~rd_byte[7];
                            state    <= BS_TX;
                        end else begin
                            sda_pull <= 1'b0;
                            state    <= BS_RX;
                        end
                    end
                end
                BS_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt == 4'd7) begin
                            sda_pull <= 1'b0;
                            state    <= BS_MACK;
                        end else begin
                            sda_pull <= ~sh[7];
                            sh       <= {sh[6:0], 1'b0};
                            cnt      <= cnt + 4'd1;
                        end
                    end
                end
                BS_MACK: begin
                    if (ev.scl_rise) state <= BS_IDLE;
                end
                default: ;
            endcase
        end
    end

    // R10
    sda_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !ev.scl);

    // R10
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !sda_pull);
endmodule

// File: rtl/trim_regfile.sv
module trim_regfile
    import trim_i2c_pkg::*;
#(
    parameter int unsigned NCH      = 8,
    parameter logic [7:0]  DAC_INIT = 8'h80,
    parameter logic [7:0]  POL_INIT = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_stb,
    input  logic              wdata_stb,
    input  logic              rd_addr_stb,
    input  logic [7:0]        rx_byte,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic [7:0]        rd_byte,
    output logic              fwd_req,
    output logic              fwd_we,
    output logic [7:0]        fwd_addr,
    output logic [7:0]        fwd_wdata,
    input  logic              fwd_done,
    input  logic [7:0]        fwd_rdata,
    output logic [NCH-1:0]    en,
    output logic [NCH-1:0]    pol,
    output logic [NCH*8-1:0]  dac_flat,
    output logic [NCH*12-1:0] tgt_flat,
    output logic [NCH-1:0]    atten
);
    target_t    tgt [NCH];
    logic [7:0] dac [NCH];
    logic [7:0] ptr;
    logic       rd_valid;
    logic [7:0] rd_buf;
    logic [7:0] rd_local;

    for (genvar c = 0; c < NCH; c++) begin : g_flat
        assign dac_flat[c*8 +: 8]   = dac[c];
        assign tgt_flat[c*12 +: 12] = tgt[c].code;
        assign atten[c]             = tgt[c].atten;
    end

    always_comb begin
        rd_local = 8'h00;
        for (int c = 0; c < NCH; c++) begin
            if (ptr == 8'(TGT_BASE + 2*c))
                rd_local = {tgt[c].atten, 3'b000, tgt[c].code[11:8]};
            if (ptr == 8'(TGT_BASE + 2*c + 1))
                rd_local = tgt[c].code[7:0];
            if (ptr == 8'(DAC_BASE + c))
                rd_local = dac[c];
        end
        if (ptr == EN_ADDR)  rd_local = 8'(en);
        if (ptr == POL_ADDR) rd_local = 8'(pol);
    end

    assign wr_ok   = !fwd_req;
    assign rd_ok   = !fwd_req && (!is_fwd(ptr) || rd_valid);
    assign rd_byte = is_fwd(ptr) ? rd_buf : rd_local;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                tgt[c] <= '0;
                dac[c] <= DAC_INIT;
            end
            en        <= '0;
            pol       <= POL_INIT[NCH-1:0];
            ptr       <= '0;
            rd_valid  <= 1'b0;
            rd_buf    <= '0;
            fwd_req   <= 1'b0;
            fwd_we    <= 1'b0;
            fwd_addr  <= '0;
            fwd_wdata <= '0;
        end else begin
            if (fwd_req && fwd_done) begin
                fwd_req <= 1'b0;
                if (!fwd_we) begin
                    rd_buf   <= fwd_rdata;
                    rd_valid <= 1'b1;
                end
            end
            if (ptr_stb) begin
                ptr      <= rx_byte;
                rd_valid <= 1'b0;
            end
            if (wdata_stb) begin
                if (is_fwd(ptr)) begin
                    fwd_req   <= 1'b1;
                    fwd_we    <= 1'b1;
                    fwd_addr  <= ptr;
                    fwd_wdata <= rx_byte;
                end else begin
                    for (int c = 0; c < NCH; c++) begin
                        if (ptr == 8'(TGT_BASE + 2*c)) begin
                            tgt[c].atten      <= rx_byte[7];
                            tgt[c].code[11:8] <= rx_byte[3:0];
                        end
                        if (ptr == 8'(TGT_BASE + 2*c + 1))
                            tgt[c].code[7:0] <= rx_byte;
                        if (ptr == 8'(DAC_BASE + c))
                            dac[c] <= rx_byte;
                    end
                    if (ptr == EN_ADDR)  en  <= rx_byte[NCH-1:0];
                    if (ptr == POL_ADDR) pol <= rx_byte[NCH-1:0];
                end
            end
            if (rd_addr_stb && is_fwd(ptr)) begin
                if (rd_ok) begin
                    rd_valid <= 1'b0;
                end else if (!fwd_req && !rd_valid) begin
                    fwd_req  <= 1'b1;
                    fwd_we   <= 1'b0;
                    fwd_addr <= ptr;
                end
            end
        end
    end

    // R6
    fwd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_req && !fwd_done |=> fwd_req && $stable(fwd_addr) && $stable(fwd_we) && $stable(fwd_wdata));

    // R6
    fwd_range_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_req |-> fwd_addr <= FWD_LAST);

    // R5
    rd_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(fwd_done));

    // R2
    en_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wdata_stb |=> $stable(en));

    // R9
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ptr == RSV_ADDR |-> rd_byte == 8'h00);
endmodule

// File: rtl/trim_reg_target.sv
module trim_reg_target
    import trim_i2c_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h20,
    parameter int unsigned NCH      = 8,
    parameter int unsigned FILT_LEN = 3,
    parameter logic [7:0]  DAC_INIT = 8'h80,
    parameter logic [7:0]  POL_INIT = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic              fwd_req_o,
    output logic              fwd_we_o,
    output logic [7:0]        fwd_addr_o,
    output logic [7:0]        fwd_wdata_o,
    input  logic              fwd_done_i,
    input  logic [7:0]        fwd_rdata_i,
    output logic [NCH-1:0]    chan_en_o,
    output logic [NCH-1:0]    chan_pol_o,
    output logic [NCH*8-1:0]  dac_code_o,
    output logic [NCH*12-1:0] tgt_code_o,
    output logic [NCH-1:0]    tgt_atten_o
);
    logic    scl_f, sda_f, scl_q, sda_q;
    bus_ev_t ev;
    logic    wr_ok, rd_ok, ptr_stb, wdata_stb, rd_addr_stb;
    logic [7:0] rd_byte, rx_byte;

    i2c_pin_sync #(.FILT_LEN(FILT_LEN)) i_scl_sync (
        .clk(clk), .rst(rst), .pin_i(scl_i), .level_o(scl_f));
    i2c_pin_sync #(.FILT_LEN(FILT_LEN)) i_sda_sync (
        .clk(clk), .rst(rst), .pin_i(sda_i), .level_o(sda_f));

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.scl      = scl_f;
        ev.sda      = sda_f;
        ev.scl_rise = scl_f && !scl_q;
        ev.scl_fall = !scl_f && scl_q;
        ev.start    = scl_f && scl_q && sda_q && !sda_f;
        ev.stop     = scl_f && scl_q && !sda_q && sda_f;
    end

    i2c_byte_engine #(.DEV_ADDR(DEV_ADDR)) i_engine (
        .clk(clk), .rst(rst), .ev(ev),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .rd_byte(rd_byte),
        .sda_pull(sda_pull_o), .ptr_stb(ptr_stb), .wdata_stb(wdata_stb),
        .rd_addr_stb(rd_addr_stb), .rx_byte(rx_byte));

    trim_regfile #(.NCH(NCH), .DAC_INIT(DAC_INIT), .POL_INIT(POL_INIT)) i_regs (
        .clk(clk), .rst(rst),
        .ptr_stb(ptr_stb), .wdata_stb(wdata_stb), .rd_addr_stb(rd_addr_stb),
        .rx_byte(rx_byte), .wr_ok(wr_ok), .rd_ok(rd_ok), .rd_byte(rd_byte),
        .fwd_req(fwd_req_o), .fwd_we(fwd_we_o), .fwd_addr(fwd_addr_o),
        .fwd_wdata(fwd_wdata_o), .fwd_done(fwd_done_i), .fwd_rdata(fwd_rdata_i),
        .en(chan_en_o), .pol(chan_pol_o), .dac_flat(dac_code_o),
        .tgt_flat(tgt_code_o), .atten(tgt_atten_o));
endmodule

// File: tb/test_trim_reg_target.sv
module test_trim_reg_target;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 16;
    localparam int RESP_LAT   = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;
    logic fwd_req, fwd_we, fwd_done;
    logic [7:0] fwd_addr, fwd_wdata, fwd_rdata;
    logic [7:0] chan_en, chan_pol, atten;
    logic [63:0] dac_code;
    logic [95:0] tgt_code;

    int checks = 0;
    int errors = 0;
    int sda_violations = 0;
    logic resp_hold = 1'b0;
    logic [7:0] last_rd_addr = 8'h00;
    int rd_launches = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    trim_reg_target i_trim_reg_target (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .fwd_req_o(fwd_req), .fwd_we_o(fwd_we),
        .fwd_addr_o(fwd_addr), .fwd_wdata_o(fwd_wdata),
        .fwd_done_i(fwd_done), .fwd_rdata_i(fwd_rdata),
        .chan_en_o(chan_en), .chan_pol_o(chan_pol), .dac_code_o(dac_code),
        .tgt_code_o(tgt_code), .tgt_atten_o(atten));

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // downstream responder
    initial begin
        fwd_done  = 1'b0;
        fwd_rdata = 8'h00;
        forever begin
            @(negedge clk);
            if (fwd_req && !resp_hold) begin
                if (!fwd_we) begin
                    last_rd_addr = fwd_addr;
                    rd_launches++;
                end
                wt(RESP_LAT);
                fwd_rdata = fwd_addr ^ 8'hA5;
                fwd_done  = 1'b1;
                @(negedge clk);
                fwd_done  = 1'b0;
                @(negedge clk);
            end
        end
    end

    // R10 monitor: no new pull while SCL is high
    initial begin
        logic pq;
        pq = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && sda_pull && !pq && scl_m) sda_violations++;
            pq = sda_pull;
        end
    end

    task automatic send_bit(input logic b);
        scl_m = 1'b0; wt(4); sda_m = b; wt(H-4); scl_m = 1'b1; wt(H);
    endtask

    task automatic read_bit(output logic v);
        scl_m = 1'b0; wt(4); sda_m = 1'b1; wt(H-4); scl_m = 1'b1; wt(H/2);
        v = sda_line; wt(H/2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; wt(4); sda_m = 1'b0; wt(H-4); scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        read_bit(nack);
    endtask

    task automatic wr3(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d,
                       output logic [2:0] nk);
        bus_start();
        send_byte({dev, 1'b0}, nk[0]);
        send_byte(ra, nk[1]);
        send_byte(d, nk[2]);
        bus_stop();
    endtask

    task automatic set_ptr(input logic [6:0] dev, input logic [7:0] ra, output logic [1:0] nk);
        bus_start();
        send_byte({dev, 1'b0}, nk[0]);
        send_byte(ra, nk[1]);
        bus_stop();
    endtask

    task automatic rd1(input logic [6:0] dev, output logic nk, output logic [7:0] d);
        logic b;
        d = 8'h00;
        bus_start();
        send_byte({dev, 1'b1}, nk);
        if (!nk) begin
            for (int i = 7; i >= 0; i--) begin
                read_bit(b);
                d[i] = b;
            end
            send_bit(1'b1);
        end
        bus_stop();
    endtask

    task automatic read_reg(input logic [7:0] ra, output logic nk, output logic [7:0] d);
        logic [1:0] pk;
        set_ptr(7'h20, ra, pk);
        rd1(7'h20, nk, d);
    endtask

    task automatic t_reset();
        chk("R7 enable reset", 32'(chan_en), 32'h00);
        chk("R7 polarity reset", 32'(chan_pol), 32'h00);
        chk("R7 dac ch1 reset", 32'(dac_code[7:0]), 32'h80);
        chk("R7 dac ch8 reset", 32'(dac_code[63:56]), 32'h80);
        chk("R7 target reset", 32'(tgt_code[31:0]), 32'h0);
        chk("R10 idle release", 32'(sda_pull), 32'h0);
        chk("R6 no request at reset", 32'(fwd_req), 32'h0);
    endtask

    task automatic t_local_write();
        logic [2:0] nk;
        logic rn;
        logic [7:0] d;
        wr3(7'h20, 8'h34, 8'h5C, nk);
        chk("R2 write acks", 32'(nk), 32'h0);
        chk("R7 dac ch5 written", 32'(dac_code[39:32]), 32'h5C);
        read_reg(8'h34, rn, d);
        chk("R3 read ack", 32'(rn), 32'h0);
        chk("R3 read dac ch5", 32'(d), 32'h5C);
        wr3(7'h20, 8'h3A, 8'h20, nk);
        wr3(7'h20, 8'h38, 8'h30, nk);
        chk("R7 polarity ch6", 32'(chan_pol), 32'h20);
        chk("R7 enable ch5 ch6", 32'(chan_en), 32'h30);
        read_reg(8'h3A, rn, d);
        chk("R3 read polarity", 32'(d), 32'h20);
    endtask

    task automatic t_target_fields();
        logic [2:0] nk;
        logic rn;
        logic [7:0] d;
        wr3(7'h20, 8'h2A, 8'hF5, nk);
        wr3(7'h20, 8'h2B, 8'hE2, nk);
        chk("R8 atten ch6 set", 32'(atten[5]), 32'h1);
        chk("R8 target ch6", 32'(tgt_code[71:60]), 32'h5E2);
        read_reg(8'h2A, rn, d);
        chk("R8 high byte unused bits zero", 32'(d), 32'h85);
        read_reg(8'h2B, rn, d);
        chk("R7 low byte readback", 32'(d), 32'hE2);
        wr3(7'h20, 8'h2A, 8'h04, nk);
        chk("R8 atten ch6 cleared", 32'(atten[5]), 32'h0);
        chk("R8 target ch6 high nibble", 32'(tgt_code[71:60]), 32'h4E2);
        wr3(7'h20, 8'h2E, 8'h8F, nk);
        chk("R7 target ch8 high", 32'(tgt_code[95:84]), 32'hF00);
    endtask

    task automatic t_wrong_dev();
        logic [2:0] nk;
        wr3(7'h21, 8'h38, 8'hFF, nk);
        chk("R1 foreign address no ack", 32'(nk), 32'h7);
        chk("R1 foreign frame ignored", 32'(chan_en), 32'h30);
    endtask

    task automatic t_reserved();
        logic [2:0] nk;
        logic rn;
        logic [7:0] d;
        wr3(7'h20, 8'h39, 8'hFF, nk);
        chk("R9 reserved write acked", 32'(nk), 32'h0);
        read_reg(8'h39, rn, d);
        chk("R9 reserved reads zero", 32'(d), 32'h00);
        wr3(7'h20, 8'h40, 8'h55, nk);
        read_reg(8'h40, rn, d);
        chk("R9 unmapped reads zero", 32'(d), 32'h00);
        chk("R9 unmapped read acked", 32'(rn), 32'h0);
        chk("R9 enable untouched", 32'(chan_en), 32'h30);
    endtask

    task automatic t_fwd_write_busy();
        logic [2:0] nk;
        resp_hold = 1'b1;
        wr3(7'h20, 8'h13, 8'h77, nk);
        chk("R6 relayed write acked", 32'(nk), 32'h0);
        chk("R6 request raised", 32'(fwd_req), 32'h1);
        chk("R6 request is write", 32'(fwd_we), 32'h1);
        chk("R6 request address", 32'(fwd_addr), 32'h13);
        chk("R6 request data", 32'(fwd_wdata), 32'h77);
        wr3(7'h20, 8'h38, 8'h0F, nk);
        chk("R4 busy address nack", 32'(nk[0]), 32'h1);
        chk("R4 busy frame ignored", 32'(chan_en), 32'h30);
        resp_hold = 1'b0;
        wt(RESP_LAT + 10);
        chk("R6 request cleared", 32'(fwd_req), 32'h0);
        wr3(7'h20, 8'h38, 8'h0F, nk);
        chk("R4 retry acked", 32'(nk), 32'h0);
        chk("R4 retry applied", 32'(chan_en), 32'h0F);
    endtask

    task automatic t_fwd_read_poll();
        logic [1:0] pk;
        logic rn;
        logic [7:0] d;
        int l0;
        l0 = rd_launches;
        set_ptr(7'h20, 8'h05, pk);
        rd1(7'h20, rn, d);
        chk("R5 first poll nack", 32'(rn), 32'h1);
        chk("R5 read launched", 32'(rd_launches - l0), 32'h1);
        chk("R5 launched address", 32'(last_rd_addr), 32'h05);
        wt(RESP_LAT + 10);
        rd1(7'h20, rn, d);
        chk("R5 later poll ack", 32'(rn), 32'h0);
        chk("R5 relayed data", 32'(d), 32'hA0);
        rd1(7'h20, rn, d);
        chk("R5 data used once", 32'(rn), 32'h1);
        wt(RESP_LAT + 10);
        rd1(7'h20, rn, d);
        chk("R5 refetch ack", 32'(rn), 32'h0);
        chk("R5 refetch data", 32'(d), 32'hA0);
    endtask

    task automatic t_extra_byte();
        logic n0, n1, n2, n3;
        bus_start();
        send_byte({7'h20, 1'b0}, n0);
        send_byte(8'h38, n1);
        send_byte(8'h01, n2);
        send_byte(8'hFF, n3);
        bus_stop();
        chk("R11 three bytes acked", 32'({n2, n1, n0}), 32'h0);
        chk("R11 fourth byte nack", 32'(n3), 32'h1);
        chk("R11 fourth byte ignored", 32'(chan_en), 32'h01);
    endtask

    initial begin
        wt(5);
        rst = 1'b0;
        wt(5);
        t_reset();
        t_local_write();
        t_target_fields();
        t_wrong_dev();
        t_reserved();
        t_fwd_write_busy();
        t_fwd_read_poll();
        t_extra_byte();
        chk("R10 no pull while SCL high", 32'(sda_violations), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule